// File: doc/BRIEF.md
# Self-Filling Product Lookup Table

This block is a 4-bit by 4-bit unsigned multiplier that works as a lookup table held in a dual-port memory. After reset, a loader running on its own clock fills the table without any outside memory image. An 8-bit fill counter visits every address once. Its upper nibble and its lower nibble become the two operands. A small multiplier forms their product, and the product is written at the address given by the counter.

When the last entry has been written, the loader stops and raises a done flag. That flag crosses into the read clock domain through a two-stage synchroniser and becomes the read-side ready signal. The user then places the two operands side by side on the read address, with the upper operand in bits [7:4] and the lower in bits [3:0]. The product appears on the read data port one read clock after the address is presented, with no further pipeline stages. Operand widths, synchroniser depth and the derived table size are all parameters.

Top module: `prod_table`

## Requirements
- R1: After loader reset is released, the fill counter starts at address 0 and advances by one on every loader clock, so the fill takes exactly 256 loader cycles.
- R2: Each entry written during the fill holds the unsigned product of counter bits [7:4] and counter bits [3:0], and it is written at the counter value itself.
- R3: The fill counter stops at 255 and does not wrap back to 0. The table is never rewritten after the fill ends.
- R4: The loader done flag rises on the clock edge that writes entry 255, and from then on it blocks all writes until the next loader reset.
- R5: `rd_ready` is low while either reset is held and while the fill is still running. It may only be high while the loader done flag is high, and it rises a few read clocks after the fill ends.
- R6: Once ready, `rd_data` equals `rd_addr[7:4] * rd_addr[3:0]` as an 8-bit unsigned value, one read clock after the address is sampled. Entry 255 gives 0xE1 and any address with a zero nibble gives 0.
- R7: A new reset, applied to both domains together, drops `rd_ready` and runs the complete fill again. The table then gives the same products as before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ld_clk | input | 1 | Loader clock, drives the fill counter and the table write port |
| ld_rst | input | 1 | Synchronous active-high reset of the loader domain |
| rd_clk | input | 1 | Read clock, drives the table read port and the ready synchroniser |
| rd_rst | input | 1 | Synchronous active-high reset of the read domain |
| rd_addr | input | 8 | Read address: upper operand in [7:4], lower operand in [3:0] |
| rd_data | output | 8 | Registered product read from the table |
| rd_ready | output | 1 | Table is fully filled, seen in the read clock domain |

## Verification
The assertions check the following on every cycle:
- the counter steps by one and never wraps;
- no write happens once the loader is done, and the done flag follows the write to entry 255;
- ready is never high without the done flag;
- every read taken while ready returns the arithmetic product of the sampled address.

Only the bench scenarios can show that the fill takes the right number of loader cycles end to end and that ready stays low before that. They also show that every one of the 256 products is correct through the ports under two address orders, and that a second reset clears ready and rebuilds the same table.

// File: rtl/mtab_pkg.sv
package mtab_pkg;
  localparam int unsigned DEF_OPW = 4;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef enum logic [0:0] {
    FILL_RUN  = 1'b0,
    FILL_DONE = 1'b1
  } fill_state_e;
endpackage

// File: rtl/mtab_fill_ctr.sv
module mtab_fill_ctr
  import mtab_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] addr,
  output logic          wr_en,
  output logic          done
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  fill_state_e state_q;
  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      state_q <= FILL_RUN;
    end else if (state_q == FILL_RUN) begin
      if (cnt_q == LAST) begin
        state_q <= FILL_DONE;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign addr  = cnt_q;
  assign wr_en = (state_q == FILL_RUN) && !rst;
  assign done  = (state_q == FILL_DONE);
endmodule

// File: rtl/mtab_mult.sv
module mtab_mult #(
  parameter int unsigned OPW = 4,
  localparam int unsigned AW = 2 * OPW
) (
  input  logic [AW-1:0] opnds,
  output logic [AW-1:0] prod
);
  logic [OPW-1:0] op_hi;
  logic [OPW-1:0] op_lo;

  assign op_hi = opnds[AW-1:OPW];
  assign op_lo = opnds[OPW-1:0];

  always_comb begin
    prod = AW'(op_hi) * AW'(op_lo);
  end
endmodule

// File: rtl/mtab_ram.sv
module mtab_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge rclk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mtab_sync.sv
module mtab_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/prod_table.sv
module prod_table
  import mtab_pkg::*;
#(
  parameter int unsigned OPW = DEF_OPW,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  localparam int unsigned AW = 2 * OPW,
  localparam int unsigned DW = 2 * OPW
) (
  input  logic          ld_clk,
  input  logic          ld_rst,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_ready
);
  logic [AW-1:0] fill_addr;
  logic          fill_we;
  logic          fill_done;
  logic [DW-1:0] fill_prod;

  mtab_fill_ctr #(.AW(AW)) u_ctr (
    .clk   (ld_clk),
    .rst   (ld_rst),
    .addr  (fill_addr),
    .wr_en (fill_we),
    .done  (fill_done)
  );

  mtab_mult #(.OPW(OPW)) u_mult (
    .opnds (fill_addr),
    .prod  (fill_prod)
  );

  mtab_ram #(.AW(AW), .DW(DW)) u_ram (
    .wclk  (ld_clk),
    .we    (fill_we),
    .waddr (fill_addr),
    .wdata (fill_prod),
    .rclk  (rd_clk),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  mtab_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (rd_clk),
    .rst (rd_rst),
    .d   (fill_done),
    .q   (rd_ready)
  );
endmodule

// File: rtl/prod_table_chk.sv
module prod_table_chk #(
  parameter int unsigned OPW = 4,
  localparam int unsigned AW = 2 * OPW
) (
  input logic          ld_clk,
  input logic          ld_rst,
  input logic          rd_clk,
  input logic          rd_rst,
  input logic [AW-1:0] fill_addr,
  input logic          fill_we,
  input logic          fill_done,
  input logic [AW-1:0] rd_addr,
  input logic [AW-1:0] rd_data,
  input logic          rd_ready
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  AST_CNT_FROM_ZERO: assert property (@(posedge ld_clk) ld_rst |=> (fill_addr == '0) && !fill_done); // R1
  AST_CNT_STEP: assert property (@(posedge ld_clk) disable iff (ld_rst)
    (!fill_done && fill_addr != LAST) |=> (fill_addr == $past(fill_addr) + 1'b1)); // R1
  AST_NO_WRAP: assert property (@(posedge ld_clk) disable iff (ld_rst)
    fill_done |=> (fill_done && fill_addr == LAST)); // R3
  AST_NO_WRITE_AFTER: assert property (@(posedge ld_clk) disable iff (ld_rst)
    fill_done |-> !fill_we); // R4
  AST_DONE_AFTER_LAST: assert property (@(posedge ld_clk) disable iff (ld_rst)
    (fill_we && fill_addr == LAST) |=> fill_done); // R4
  AST_READY_NEEDS_DONE: assert property (@(posedge rd_clk) disable iff (rd_rst || ld_rst)
    rd_ready |-> fill_done); // R5
  AST_READ_PRODUCT: assert property (@(posedge rd_clk) disable iff (rd_rst || ld_rst)
    rd_ready |=> (rd_data == AW'($past(rd_addr[AW-1:OPW])) * AW'($past(rd_addr[OPW-1:0])))); // R6
endmodule

bind prod_table prod_table_chk #(.OPW(OPW)) u_chk (
  .ld_clk    (ld_clk),
  .ld_rst    (ld_rst),
  .rd_clk    (rd_clk),
  .rd_rst    (rd_rst),
  .fill_addr (fill_addr),
  .fill_we   (fill_we),
  .fill_done (fill_done),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .rd_ready  (rd_ready)
);

// File: tb/prod_table_tb_top.sv
module prod_table_tb_top;
  localparam int LD_PERIOD = 10;
  localparam int RD_PERIOD = 7;
  localparam int WATCHDOG_CYCLES = 100000;

  logic       ld_clk = 1'b0;
  logic       rd_clk = 1'b0;
  logic       ld_rst = 1'b1;
  logic       rd_rst = 1'b1;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       rd_ready;

  int n_checks = 0;
  int n_fail = 0;
  int ld_edges = 0;
  bit finished = 1'b0;

  always #(LD_PERIOD / 2) ld_clk = ~ld_clk;
  always #(RD_PERIOD / 2.0) rd_clk = ~rd_clk;
  always @(posedge ld_clk) ld_edges <= ld_edges + 1;

  prod_table dut_i (
    .ld_clk   (ld_clk),
    .ld_rst   (ld_rst),
    .rd_clk   (rd_clk),
    .rd_rst   (rd_rst),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .rd_ready (rd_ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_prod(input logic [7:0] a);
    return 8'((int'(a[7:4]) * int'(a[3:0])) & 255);
  endfunction

  task automatic read_check(input logic [7:0] a, input string req);
    @(negedge rd_clk);
    rd_addr = a;
    @(negedge rd_clk);
    check(rd_data == ref_prod(a), req, int'(rd_data), int'(ref_prod(a)));
  endtask

  task automatic do_reset();
    ld_rst = 1'b1;
    rd_rst = 1'b1;
    repeat (6) @(negedge ld_clk);
    check(rd_ready == 1'b0, "R5 ready low in reset", int'(rd_ready), 0);
    ld_rst = 1'b0;
    rd_rst = 1'b0;
  endtask

  task automatic run_fill(input string req);
    int start;
    int waited;
    start = ld_edges;
    repeat (100) @(negedge ld_clk);
    check(rd_ready == 1'b0, "R5 ready low mid-fill", int'(rd_ready), 0);
    waited = 0;
    while (!rd_ready && waited < 2000) begin
      @(negedge rd_clk);
      waited++;
    end
    check((ld_edges - start) >= 256 && (ld_edges - start) <= 260, req,
          ld_edges - start, 256);
  endtask

  initial begin
    do_reset();
    run_fill("R1 fill length");
    check(rd_ready == 1'b1, "R5 ready raised", int'(rd_ready), 1);
    for (int i = 0; i < 256; i++) read_check(8'(i), "R2 R6 linear sweep");
    for (int i = 0; i < 256; i++) read_check(8'((i * 37 + 11) & 255), "R6 strided sweep");
    read_check(8'hFF, "R6 corner 15x15");
    read_check(8'h0F, "R6 zero upper operand");
    read_check(8'hF0, "R6 zero lower operand");
    repeat (400) @(negedge ld_clk);
    check(rd_ready == 1'b1, "R4 ready held after fill", int'(rd_ready), 1);
    read_check(8'h00, "R3 entry 0 not overwritten");
    read_check(8'h11, "R3 entry 17 not overwritten");
    read_check(8'hFF, "R3 entry 255 intact");
    do_reset();
    @(negedge rd_clk);
    check(rd_ready == 1'b0, "R7 ready dropped after reset", int'(rd_ready), 0);
    run_fill("R7 refill length");
    for (int i = 0; i < 256; i += 5) read_check(8'(i), "R7 table after refill");
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge ld_clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule